// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired control unit of a 32-bit multicycle load/store processor in which one memory and one ALU are shared across the steps of each instruction. A binary-encoded state register walks through fetch, decode and one to three further steps per instruction. Every control line going to the datapath is decoded from the current state alone. The one exception is the PC write enable, which also folds in the ALU zero flag for the conditional branch.

The sequencer handles five instruction classes: register-register ALU operations, OR with an immediate, word load, word store and branch-on-equal. It also has two exception steps. An opcode that decode does not recognise, or an ALU overflow during a register-register execute step, sends the machine to an exception step. That step uses the ALU to back the PC up by 4 into the exception PC register, writes a cause code, and redirects the PC to the fixed handler address. The datapath provides the handler address constant, selected by `pc_src`.

Top module: `mcyc_ctrl`

## Requirements
- R1: Synchronous active-high `rst` forces the fetch step at the next rising edge, whatever step the machine is in and whatever the inputs are. A reset asserted during a step leaves that step's outputs unchanged for the rest of the cycle.
- R2: The fetch step drives the following and nothing else: `mem_rd`=1, `addr_sel`=0 (PC), `ir_we`=1, `a_sel`=0 (PC), `b_sel`=001 (constant 4), `alu_op`=00 (add), `pc_src`=00 (ALU result) and `pc_we`=1. Fetch is always followed by decode.
- R3: The decode step drives `a_sel`=0, `b_sel`=011 (sign-extended imm16 shifted left 2) and `alu_op`=00, with every enable low. It then dispatches on the opcode: 000000 register-register, 001101 OR-immediate, 100011 load, 101011 store, 000100 branch.
- R4: A load takes three steps after decode. Execute drives `a_sel`=1, `b_sel`=010 (sign-extended imm16) and `alu_op`=00. Memory access drives `mem_rd`=1 and `addr_sel`=1 (ALU out). Write-back drives `reg_we`=1, `dst_sel`=0 (rt) and `wb_sel`=1 (memory data).
- R5: A store takes two steps after decode. Execute is the same as for a load. Memory access drives `mem_wr`=1, `addr_sel`=1 and no register write.
- R6: A register-register instruction executes with `a_sel`=1, `b_sel`=000 (rt) and `alu_op`=10 (function field). If `alu_ovf` is low, the next step writes back with `reg_we`=1, `dst_sel`=1 (rd) and `wb_sel`=0 (ALU out).
- R7: OR-immediate executes with `a_sel`=1, `b_sel`=100 (zero-extended imm16) and `alu_op`=11 (OR). It then writes back with `reg_we`=1, `dst_sel`=0 and `wb_sel`=0.
- R8: Branch executes in one step: `a_sel`=1, `b_sel`=000, `alu_op`=01 (subtract) and `pc_src`=01 (ALU out). In that step `pc_we` equals `alu_zero`. In every other non-exception step `alu_zero` has no effect on `pc_we`.
- R9: Any other opcode in decode leads to an exception step with `epc_we`=1, `cause_we`=1, `cause_code`=10, `a_sel`=0, `b_sel`=001, `alu_op`=01 (PC-4), `pc_src`=10 (handler address) and `pc_we`=1.
- R10: If `alu_ovf` is high in the register-register execute step, the next step is the exception step with `cause_code`=12 (other outputs as in R9), and no register write happens.
- R11: `alu_ovf` is ignored in every step except register-register execute. Outside the exception steps, `cause_code` is 0 and `epc_we`/`cause_we` are low.
- R12: Every final instruction step and both exception steps are followed by fetch.
- R13: `mem_rd` and `mem_wr` are never high together, and `reg_we` never coincides with `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| alu_ovf | input | 1 | ALU signed overflow flag |
| pc_we | output | 1 | PC write enable (unconditional, or conditional on zero) |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU out register, 10 handler address |
| ir_we | output | 1 | Instruction register write enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU out register |
| reg_we | output | 1 | Register file write enable |
| dst_sel | output | 1 | Destination register: 0 rt, 1 rd |
| wb_sel | output | 1 | Write data: 0 ALU out, 1 memory data register |
| a_sel | output | 1 | First ALU operand: 0 PC, 1 register A |
| b_sel | output | 3 | Second ALU operand select |
| alu_op | output | 2 | ALU operation: 00 add, 01 sub, 10 function, 11 OR |
| epc_we | output | 1 | Exception PC register write enable |
| cause_we | output | 1 | Cause register write enable |
| cause_code | output | 5 | Cause value written on an exception |

## Verification
The register-register execute step is the one cycle where the normal path (prepare the rd write-back) and the exception path (record EPC and cause) compete for the next state. An overflow decides between them. The bench raises `alu_ovf` in that execute cycle to provoke the collision. It then judges the following cycle: the exception outputs with cause 12 must appear, and `reg_we` must be low. The bench also raises `alu_ovf` in decode, in load execute and in OR-immediate execute, and there it expects the normal sequence unchanged. In the same way, `alu_zero` is driven high outside the branch step, and `pc_we` must not follow it.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int OP_W     = 6;
    localparam int CAUSE_W  = 5;
    localparam int ST_W     = 4;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;

    localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = 5'd10;
    localparam logic [CAUSE_W-1:0] CAUSE_OVF   = 5'd12;

    typedef enum logic [ST_W-1:0] {
        S_FETCH   = 4'd0,
        S_DECODE  = 4'd1,
        S_LD_EXE  = 4'd2,
        S_LD_MEM  = 4'd3,
        S_LD_WB   = 4'd4,
        S_ST_EXE  = 4'd5,
        S_ST_MEM  = 4'd6,
        S_RR_EXE  = 4'd7,
        S_RR_WB   = 4'd8,
        S_OI_EXE  = 4'd9,
        S_OI_WB   = 4'd10,
        S_BR_EXE  = 4'd11,
        S_X_UNDEF = 4'd12,
        S_X_OVF   = 4'd13
    } step_t;

    typedef enum logic [1:0] {
        AOP_ADD  = 2'b00,
        AOP_SUB  = 2'b01,
        AOP_FUNC = 2'b10,
        AOP_OR   = 2'b11
    } aop_t;

    typedef enum logic [2:0] {
        BS_RT    = 3'b000,
        BS_FOUR  = 3'b001,
        BS_SEXT  = 3'b010,
        BS_SEXT2 = 3'b011,
        BS_ZEXT  = 3'b100
    } bsel_t;

    typedef enum logic [1:0] {
        PS_ALU     = 2'b00,
        PS_ALUOUT  = 2'b01,
        PS_HANDLER = 2'b10
    } psrc_t;

    typedef struct packed {
        logic               pc_wr;
        logic               pc_wr_cond;
        psrc_t              pc_src;
        logic               ir_we;
        logic               mem_rd;
        logic               mem_wr;
        logic               addr_sel;
        logic               reg_we;
        logic               dst_sel;
        logic               wb_sel;
        logic               a_sel;
        bsel_t              b_sel;
        aop_t               alu_op;
        logic               epc_we;
        logic               cause_we;
        logic [CAUSE_W-1:0] cause;
    } ctrl_t;

    function automatic ctrl_t ctrl_idle();
        ctrl_t c;
        c = '0;
        c.pc_src = PS_ALU;
        c.b_sel  = BS_RT;
        c.alu_op = AOP_ADD;
        return c;
    endfunction

    function automatic step_t dispatch(input logic [OP_W-1:0] op);
        step_t s;
        case (op)
            OPC_RTYPE: s = S_RR_EXE;
            OPC_ORI:   s = S_OI_EXE;
            OPC_LOAD:  s = S_LD_EXE;
            OPC_STORE: s = S_ST_EXE;
            OPC_BEQ:   s = S_BR_EXE;
            default:   s = S_X_UNDEF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mcyc_next.sv
module mcyc_next
    import mcyc_pkg::*;
(
    input  step_t           cur,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_ovf,
    output step_t           nxt
);
    always_comb begin
        case (cur)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: nxt = dispatch(opcode);
            S_LD_EXE: nxt = S_LD_MEM;
            S_LD_MEM: nxt = S_LD_WB;
            S_ST_EXE: nxt = S_ST_MEM;
            S_RR_EXE: nxt = alu_ovf ? S_X_OVF : S_RR_WB;
            S_OI_EXE: nxt = S_OI_WB;
            default:  nxt = S_FETCH;
        endcase
    end
endmodule

// File: rtl/mcyc_decode.sv
module mcyc_decode
    import mcyc_pkg::*;
(
    input  step_t cur,
    input  logic  alu_zero,
    output ctrl_t ctl,
    output logic  pc_we
);
    always_comb begin
        ctl = ctrl_idle();
        case (cur)
            S_FETCH: begin
                ctl.mem_rd = 1'b1;
                ctl.ir_we  = 1'b1;
                ctl.b_sel  = BS_FOUR;
                ctl.pc_wr  = 1'b1;
            end
            S_DECODE: ctl.b_sel = BS_SEXT2;
            S_LD_EXE, S_ST_EXE: begin
                ctl.a_sel = 1'b1;
                ctl.b_sel = BS_SEXT;
            end
            S_LD_MEM: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            S_LD_WB: begin
                ctl.reg_we = 1'b1;
                ctl.wb_sel = 1'b1;
            end
            S_ST_MEM: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            S_RR_EXE: begin
                ctl.a_sel  = 1'b1;
                ctl.alu_op = AOP_FUNC;
            end
            S_RR_WB: begin
                ctl.reg_we  = 1'b1;
                ctl.dst_sel = 1'b1;
            end
            S_OI_EXE: begin
                ctl.a_sel  = 1'b1;
                ctl.b_sel  = BS_ZEXT;
                ctl.alu_op = AOP_OR;
            end
            S_OI_WB: ctl.reg_we = 1'b1;
            S_BR_EXE: begin
                ctl.a_sel      = 1'b1;
                ctl.alu_op     = AOP_SUB;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = PS_ALUOUT;
            end
            S_X_UNDEF, S_X_OVF: begin
                ctl.b_sel    = BS_FOUR;
                ctl.alu_op   = AOP_SUB;
                ctl.epc_we   = 1'b1;
                ctl.cause_we = 1'b1;
                ctl.cause    = (cur == S_X_OVF) ? CAUSE_OVF : CAUSE_UNDEF;
                ctl.pc_wr    = 1'b1;
                ctl.pc_src   = PS_HANDLER;
            end
            default: ctl = ctrl_idle();
        endcase
    end

    assign pc_we = ctl.pc_wr | (ctl.pc_wr_cond & alu_zero);
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [OP_W-1:0]    opcode,
    input  logic               alu_zero,
    input  logic               alu_ovf,
    output logic               pc_we,
    output logic [1:0]         pc_src,
    output logic               ir_we,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               addr_sel,
    output logic               reg_we,
    output logic               dst_sel,
    output logic               wb_sel,
    output logic               a_sel,
    output logic [2:0]         b_sel,
    output logic [1:0]         alu_op,
    output logic               epc_we,
    output logic               cause_we,
    output logic [CAUSE_W-1:0] cause_code
);
    step_t cur_q;
    step_t nxt;
    ctrl_t ctl;

    always_ff @(posedge clk) begin
        if (rst) cur_q <= S_FETCH;
        else     cur_q <= nxt;
    end

    mcyc_next u_next (
        .cur     (cur_q),
        .opcode  (opcode),
        .alu_ovf (alu_ovf),
        .nxt     (nxt)
    );

    mcyc_decode u_decode (
        .cur      (cur_q),
        .alu_zero (alu_zero),
        .ctl      (ctl),
        .pc_we    (pc_we)
    );

    assign pc_src     = ctl.pc_src;
    assign ir_we      = ctl.ir_we;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign addr_sel   = ctl.addr_sel;
    assign reg_we     = ctl.reg_we;
    assign dst_sel    = ctl.dst_sel;
    assign wb_sel     = ctl.wb_sel;
    assign a_sel      = ctl.a_sel;
    assign b_sel      = ctl.b_sel;
    assign alu_op     = ctl.alu_op;
    assign epc_we     = ctl.epc_we;
    assign cause_we   = ctl.cause_we;
    assign cause_code = ctl.cause;
endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       alu_zero,
    input logic       alu_ovf,
    input logic       pc_we,
    input logic [1:0] pc_src,
    input logic       ir_we,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       reg_we,
    input logic       dst_sel,
    input logic       a_sel,
    input logic [2:0] b_sel,
    input logic [1:0] alu_op,
    input logic       epc_we,
    input logic [4:0] cause_code
);
    // R1: reset leads to fetch
    a_r1_reset_fetch: assert property (@(posedge clk)
        rst |=> (ir_we && mem_rd && pc_we));

    // R3: fetch is followed by decode
    a_r3_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
        ir_we |=> (b_sel == 3'b011 && !pc_we && !mem_rd));

    // R6: clean register-register execute reaches an rd write-back
    a_r6_rr_writeback: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 2'b10 && !alu_ovf) |=> (reg_we && dst_sel));

    // R8: branch step writes PC exactly when zero
    a_r8_branch_cond: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 2'b01 && a_sel) |-> (pc_we == alu_zero && pc_src == 2'b01));

    // R10: overflow in execute diverts to the exception step
    a_r10_no_overflow_write: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 2'b10 && alu_ovf) |=> (epc_we && cause_code == 5'd12 && !reg_we));

    // R12: exception step returns to fetch
    a_r12_exc_returns: assert property (@(posedge clk) disable iff (rst)
        epc_we |=> (ir_we && mem_rd));

    // R13: memory strobes exclusive, no register write during store
    a_r13_mem_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr) && !(reg_we && mem_wr));
endmodule

bind mcyc_ctrl mcyc_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .alu_zero   (alu_zero),
    .alu_ovf    (alu_ovf),
    .pc_we      (pc_we),
    .pc_src     (pc_src),
    .ir_we      (ir_we),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .reg_we     (reg_we),
    .dst_sel    (dst_sel),
    .a_sel      (a_sel),
    .b_sel      (b_sel),
    .alu_op     (alu_op),
    .epc_we     (epc_we),
    .cause_code (cause_code)
);

// File: tb/mcyc_ctrl_tb.sv
`timescale 1ns/1ps
module mcyc_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b000000;
    logic       alu_zero = 1'b0;
    logic       alu_ovf = 1'b1;
    logic       pc_we, ir_we, mem_rd, mem_wr, addr_sel, reg_we, dst_sel, wb_sel, a_sel;
    logic       epc_we, cause_we;
    logic [1:0] pc_src, alu_op;
    logic [2:0] b_sel;
    logic [4:0] cause_code;

    int checks = 0;
    int failures = 0;

    logic [22:0] q_exp[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    mcyc_ctrl u_dut (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero), .alu_ovf(alu_ovf),
        .pc_we(pc_we), .pc_src(pc_src), .ir_we(ir_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .addr_sel(addr_sel), .reg_we(reg_we), .dst_sel(dst_sel), .wb_sel(wb_sel),
        .a_sel(a_sel), .b_sel(b_sel), .alu_op(alu_op), .epc_we(epc_we),
        .cause_we(cause_we), .cause_code(cause_code)
    );

    localparam logic [5:0] OP_RR = 6'b000000, OP_OI = 6'b001101, OP_LD = 6'b100011,
                           OP_ST = 6'b101011, OP_BR = 6'b000100;

    // field order: pc_we pc_src ir mrd mwr asel rwe dst wb a b op epc cwe cause
    function automatic logic [22:0] mk(input logic pw, input logic [1:0] ps, input logic ir,
        input logic mr, input logic mw, input logic ad, input logic rw, input logic ds,
        input logic wb, input logic a, input logic [2:0] b, input logic [1:0] op,
        input logic ep, input logic cw, input logic [4:0] cc);
        return {pw, ps, ir, mr, mw, ad, rw, ds, wb, a, b, op, ep, cw, cc};
    endfunction

    function automatic logic [22:0] v_fetch();  return mk(1,2'b00,1,1,0,0,0,0,0,0,3'b001,2'b00,0,0,5'd0); endfunction
    function automatic logic [22:0] v_dec();    return mk(0,2'b00,0,0,0,0,0,0,0,0,3'b011,2'b00,0,0,5'd0); endfunction
    function automatic logic [22:0] v_adr();    return mk(0,2'b00,0,0,0,0,0,0,0,1,3'b010,2'b00,0,0,5'd0); endfunction
    function automatic logic [22:0] v_ldmem();  return mk(0,2'b00,0,1,0,1,0,0,0,0,3'b000,2'b00,0,0,5'd0); endfunction
    function automatic logic [22:0] v_ldwb();   return mk(0,2'b00,0,0,0,0,1,0,1,0,3'b000,2'b00,0,0,5'd0); endfunction
    function automatic logic [22:0] v_stmem();  return mk(0,2'b00,0,0,1,1,0,0,0,0,3'b000,2'b00,0,0,5'd0); endfunction
    function automatic logic [22:0] v_rrexe();  return mk(0,2'b00,0,0,0,0,0,0,0,1,3'b000,2'b10,0,0,5'd0); endfunction
    function automatic logic [22:0] v_rrwb();   return mk(0,2'b00,0,0,0,0,1,1,0,0,3'b000,2'b00,0,0,5'd0); endfunction
    function automatic logic [22:0] v_oiexe();  return mk(0,2'b00,0,0,0,0,0,0,0,1,3'b100,2'b11,0,0,5'd0); endfunction
    function automatic logic [22:0] v_oiwb();   return mk(0,2'b00,0,0,0,0,1,0,0,0,3'b000,2'b00,0,0,5'd0); endfunction
    function automatic logic [22:0] v_br(input logic z);
        return mk(z,2'b01,0,0,0,0,0,0,0,1,3'b000,2'b01,0,0,5'd0);
    endfunction
    function automatic logic [22:0] v_exc(input logic [4:0] c);
        return mk(1,2'b10,0,0,0,0,0,0,0,0,3'b001,2'b01,1,1,c);
    endfunction

    // driver: set inputs for the cycle just begun and queue the expected outputs
    task automatic step(input logic r, input logic [5:0] op, input logic z, input logic ov,
                        input logic [22:0] e, input string tag);
        @(posedge clk);
        #1;
        rst = r; opcode = op; alu_zero = z; alu_ovf = ov;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (q_exp.size() > 0) begin
                logic [22:0] e;
                logic [22:0] act;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                act = {pc_we, pc_src, ir_we, mem_rd, mem_wr, addr_sel, reg_we, dst_sel,
                       wb_sel, a_sel, b_sel, alu_op, epc_we, cause_we, cause_code};
                checks++;
                if (act !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, act, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: held reset with overflow and an R-type opcode present
        for (int i = 0; i < 3; i++) step(1, OP_RR, 1, 1, v_fetch(), "R1");

        // R2 R3 R4: load, overflow high in decode and in execute (R11)
        step(0, OP_LD, 0, 0, v_fetch(), "R2");
        step(0, OP_LD, 0, 1, v_dec(),   "R3");
        step(0, OP_LD, 1, 1, v_adr(),   "R4 R11");
        step(0, OP_LD, 1, 0, v_ldmem(), "R4");
        step(0, OP_LD, 0, 0, v_ldwb(),  "R4");

        // R5 store
        step(0, OP_ST, 0, 0, v_fetch(), "R12");
        step(0, OP_ST, 0, 0, v_dec(),   "R3");
        step(0, OP_ST, 0, 0, v_adr(),   "R5");
        step(0, OP_ST, 0, 0, v_stmem(), "R5");

        // R6 register-register clean
        step(0, OP_RR, 0, 0, v_fetch(), "R12");
        step(0, OP_RR, 0, 0, v_dec(),   "R3");
        step(0, OP_RR, 1, 0, v_rrexe(), "R6");
        step(0, OP_RR, 1, 1, v_rrwb(),  "R6 R11");

        // R7 OR-immediate with overflow and zero high in execute (R11, R8)
        step(0, OP_OI, 0, 0, v_fetch(), "R12");
        step(0, OP_OI, 0, 0, v_dec(),   "R3");
        step(0, OP_OI, 1, 1, v_oiexe(), "R7 R8");
        step(0, OP_OI, 0, 0, v_oiwb(),  "R7 R11");

        // R8 branch not taken then taken
        step(0, OP_BR, 0, 0, v_fetch(), "R12");
        step(0, OP_BR, 0, 0, v_dec(),   "R3");
        step(0, OP_BR, 0, 0, v_br(0),   "R8");
        step(0, OP_BR, 0, 0, v_fetch(), "R12");
        step(0, OP_BR, 0, 0, v_dec(),   "R3");
        step(0, OP_BR, 1, 0, v_br(1),   "R8");

        // R9 undefined opcodes
        step(0, 6'b111111, 0, 0, v_fetch(),      "R12");
        step(0, 6'b111111, 0, 0, v_dec(),        "R3");
        step(0, 6'b111111, 0, 0, v_exc(5'd10),   "R9");
        step(0, 6'b000010, 0, 0, v_fetch(),      "R12");
        step(0, 6'b000010, 0, 0, v_dec(),        "R3");
        step(0, 6'b000010, 0, 0, v_exc(5'd10),   "R9");

        // R10 overflow collides with the write-back path
        step(0, OP_RR, 0, 0, v_fetch(),     "R12");
        step(0, OP_RR, 0, 1, v_dec(),       "R3 R11");
        step(0, OP_RR, 0, 1, v_rrexe(),     "R10");
        step(0, OP_RR, 0, 0, v_exc(5'd12),  "R10");
        step(0, OP_RR, 0, 0, v_fetch(),     "R12");

        // R1: reset in the middle of a load execute step
        step(0, OP_LD, 0, 0, v_dec(),   "R3");
        step(1, OP_LD, 0, 0, v_adr(),   "R1");
        step(0, OP_LD, 0, 0, v_fetch(), "R1");
        step(0, OP_LD, 0, 0, v_dec(),   "R3");

        repeat (2) @(posedge clk);
        #2;
        if (q_exp.size() != 0) begin
            failures++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", q_exp.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule